// File: doc/BRIEF.md
# DMA Wrap Address Generator

This block generates addresses for one side of a DMA channel, either the source or the destination, and handles address wrapping. A channel uses two identical copies, one for each side. Each copy keeps a begin pointer, a working address, a wrap counter, a wrap-size shadow and a signed wrap step. Every burst-done strobe uses up one burst from the counter. When the last burst is used, the begin pointer moves by the wrap step. In the same cycle the working address restarts from the moved pointer and the counter reloads from the shadow.

Configuration enters through a plain write port: an enable, a 2-bit target select and a 32-bit data word. The select codes are 0 for begin pointer, 1 for wrap size and 2 for wrap step. Code 3 is reserved. The block has no streaming data path, so every pin is a plain level or strobe with no back-pressure. A halt input freezes the block so that the counter, pointer and address can be read where they stopped. Bus transfers and per-burst address stepping are handled elsewhere and only read `cur_addr`.

Top module: `dma_wrap_agen`

## Requirements
- R1: After reset, `cur_addr`, `begin_ptr`, `wrap_count` and `cfg_err` are all 0. The stored step and the wrap-size shadow are also 0.
- R2: A write with select 0 loads `cfg_wdata` into both `begin_ptr` and `cur_addr`. A write with select 1 loads `cfg_wdata[15:0]` into both the shadow and `wrap_count`. A write with select 3 changes nothing.
- R3: A burst-done strobe decrements `wrap_count` by one when the count is greater than 1.
- R4: A burst-done strobe when `wrap_count` is 1 is an expiry. On the next edge, `begin_ptr` becomes the old pointer plus the step sign-extended to 32 bits, modulo 2^32. `cur_addr` equals that new pointer, and `wrap_count` reloads from the shadow.
- R5: A burst-done strobe when `wrap_count` is 0 changes nothing.
- R6: A step write (select 2) is accepted only when `cfg_wdata[15:0]`, read as two's complement, lies in -4096..4095, which means bits 15:12 are all equal. Any other value leaves the stored step unchanged and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R7: While `halt` is 1, writes and burst-done strobes are ignored. `cur_addr`, `begin_ptr`, `wrap_count` and `cfg_err` keep their values.
- R8: If a write and a burst-done strobe arrive in the same cycle, the write decides the registers it targets. Any other register follows the strobe. An expiry in that cycle uses the step that was stored before the cycle.
- R9: A step of 0 leaves `begin_ptr` unchanged on expiry, and `cur_addr` returns to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Write target: 0 begin, 1 wrap size, 2 wrap step, 3 reserved |
| cfg_wdata | input | 32 | Write data |
| burst_done | input | 1 | One burst has completed |
| halt | input | 1 | Freeze all state |
| cur_addr | output | 32 | Working address |
| begin_ptr | output | 32 | Begin-address pointer |
| wrap_count | output | 16 | Bursts remaining before the next wrap |
| cfg_err | output | 1 | Sticky flag for an out-of-range step write |

## Verification
The bench sweeps wrap sizes 0 to 3 against a set of steps. The set covers both range limits (0x0FFF and 0xF000), the values just outside them (0x1000 and 0xEFFF), 0x8000, 0x7FFF and zero. Each step is run from a base of zero and from a base near 2^32, so positive and negative steps cross the 32-bit boundary.

Each corner case catches a specific kind of fault:
- A design that zero-extends the step would move forward when it should move backward.
- A design that checks range on the wrong bits would accept 0x1000 or reject 0xF000.
- A design whose counter wraps below zero would start wrapping with a size of 0.
- A design that lets halt gate only the strobe would still take writes while halted.
- A design that forwards a step written in the expiry cycle would land the pointer in the wrong place.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic [1:0] {
    SEL_BEGIN = 2'd0,
    SEL_SIZE  = 2'd1,
    SEL_STEP  = 2'd2,
    SEL_RSVD  = 2'd3
  } wag_sel_e;
endpackage

// File: rtl/wag_step_reg.sv
// Signed wrap step storage with range check and sticky error.
module wag_step_reg #(
  parameter int STEP_W = 16,
  parameter int LIM_W  = 13   // legal range is -2^(LIM_W-1) .. 2^(LIM_W-1)-1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STEP_W-1:0] wr_data,
  output logic [STEP_W-1:0] step_q,
  output logic              err_q
);
  localparam int HI_W = STEP_W - LIM_W + 1;

  logic [HI_W-1:0] hi_bits;
  logic            in_range;

  assign hi_bits  = wr_data[STEP_W-1:LIM_W-1];
  assign in_range = (&hi_bits) | ~(|hi_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      if (in_range) step_q <= wr_data;
      else          err_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/wag_counter.sv
// Wrap counter with reload shadow; flags expiry combinationally.
module wag_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             burst_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] shadow_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = burst_ok && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (wr_en) begin
      cnt_q    <= wr_data;
      shadow_q <= wr_data;
    end else if (expire) begin
      cnt_q <= shadow_q;
    end else if (burst_ok && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/wag_pointer.sv
// Begin pointer and working address; pointer moves by the signed step on expiry.
module wag_pointer #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              expire,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] begin_q,
  output logic [ADDR_W-1:0] cur_q
);
  localparam int EXT_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] step_ext;
  logic [ADDR_W-1:0] moved;

  generate
    if (EXT_W > 0) begin : g_ext
      assign step_ext = {{EXT_W{step[STEP_W-1]}}, step};
    end else begin : g_same
      assign step_ext = step[ADDR_W-1:0];
    end
  endgenerate

  assign moved = begin_q + step_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      begin_q <= '0;
      cur_q   <= '0;
    end else if (wr_en) begin
      begin_q <= wr_data;
      cur_q   <= wr_data;
    end else if (expire) begin
      begin_q <= moved;
      cur_q   <= moved;
    end
  end
endmodule

// File: rtl/dma_wrap_agen.sv
module dma_wrap_agen
  import wag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 16,
  parameter int LIM_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              burst_done,
  input  logic              halt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] begin_ptr,
  output logic [CNT_W-1:0]  wrap_count,
  output logic              cfg_err
);
  logic              active;
  logic              wr_begin, wr_size, wr_step;
  logic              burst_ok, expire;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  shadow_q;
  logic              unused_hi;

  assign active    = !halt;
  assign wr_begin  = active && cfg_we && (cfg_sel == SEL_BEGIN);
  assign wr_size   = active && cfg_we && (cfg_sel == SEL_SIZE);
  assign wr_step   = active && cfg_we && (cfg_sel == SEL_STEP);
  assign burst_ok  = active && burst_done;
  assign unused_hi = ^{cfg_wdata[ADDR_W-1:STEP_W], shadow_q};

  wag_step_reg #(.STEP_W(STEP_W), .LIM_W(LIM_W)) u_step (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_step),
    .wr_data(cfg_wdata[STEP_W-1:0]), .step_q(step_q), .err_q(cfg_err)
  );

  wag_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_size),
    .wr_data(cfg_wdata[CNT_W-1:0]), .burst_ok(burst_ok),
    .cnt_q(wrap_count), .shadow_q(shadow_q), .expire(expire)
  );

  wag_pointer #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_begin), .wr_data(cfg_wdata),
    .expire(expire), .step(step_q), .begin_q(begin_ptr), .cur_q(cur_addr)
  );
endmodule

// File: rtl/wag_checker.sv
module wag_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              burst_done,
  input logic              halt,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] begin_ptr,
  input logic [CNT_W-1:0]  wrap_count,
  input logic              cfg_err
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R7: halt freezes everything readable
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(cur_addr) && $stable(begin_ptr) && $stable(wrap_count) && $stable(cfg_err)));

  // R3: plain decrement
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && burst_done && !cfg_we && wrap_count > ONE) |=> (wrap_count == $past(wrap_count) - ONE));

  // R4: on expiry the working address restarts from the moved pointer
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && burst_done && !cfg_we && wrap_count == ONE) |=> (cur_addr == begin_ptr));

  // R5: idle counter ignores bursts
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && burst_done && !cfg_we && wrap_count == '0) |=>
      ($stable(wrap_count) && $stable(begin_ptr) && $stable(cur_addr)));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind dma_wrap_agen wag_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .burst_done(burst_done), .halt(halt),
  .cur_addr(cur_addr), .begin_ptr(begin_ptr), .wrap_count(wrap_count), .cfg_err(cfg_err)
);

// File: tb/sim_dma_wrap_agen.sv
`timescale 1ns/1ps
module sim_dma_wrap_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        burst_done = 1'b0;
  logic        halt = 1'b0;
  logic [31:0] cur_addr, begin_ptr;
  logic [15:0] wrap_count;
  logic        cfg_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected state
  logic [31:0] m_beg, m_cur;
  logic [15:0] m_cnt, m_sh, m_step;
  logic        m_err;

  always #4 clk = ~clk;   // 125 MHz

  dma_wrap_agen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .burst_done(burst_done), .halt(halt), .cur_addr(cur_addr), .begin_ptr(begin_ptr),
    .wrap_count(wrap_count), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "cur_addr", cur_addr, m_cur);
    chk(tag, "begin_ptr", begin_ptr, m_beg);
    chk(tag, "wrap_count", {16'd0, wrap_count}, {16'd0, m_cnt});
    chk(tag, "cfg_err", {31'd0, cfg_err}, {31'd0, m_err});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; burst_done = 0; halt = 0;
    @(posedge clk); @(posedge clk); #1;
    m_beg = '0; m_cur = '0; m_cnt = '0; m_sh = '0; m_step = '0; m_err = 1'b0;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle of stimulus with the model advanced from the requirements
  task automatic cyc(input string tag, input bit we, input logic [1:0] sel,
                     input logic [31:0] d, input bit bd, input bit h);
    logic [31:0] nb, nc;
    logic [15:0] ncnt, nsh, nst;
    logic        ne;
    nb = m_beg; nc = m_cur; ncnt = m_cnt; nsh = m_sh; nst = m_step; ne = m_err;
    if (!h) begin
      if (bd && m_cnt != 16'd0) begin
        if (m_cnt == 16'd1) begin
          nb = m_beg + {{16{m_step[15]}}, m_step};
          nc = nb; ncnt = m_sh;
        end else ncnt = m_cnt - 16'd1;
      end
      if (we) begin
        case (sel)
          2'd0: begin nb = d; nc = d; end
          2'd1: begin nsh = d[15:0]; ncnt = d[15:0]; end
          2'd2: if (d[15:12] == 4'h0 || d[15:12] == 4'hF) nst = d[15:0]; else ne = 1'b1;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d; burst_done = bd; halt = h;
    @(posedge clk); #1;
    m_beg = nb; m_cur = nc; m_cnt = ncnt; m_sh = nsh; m_step = nst; m_err = ne;
    compare(tag);
    @(negedge clk);
    cfg_we = 0; burst_done = 0; halt = 0;
  endtask

  function automatic string burst_tag();
    if (m_cnt == 16'd0) return "R5";
    if (m_cnt == 16'd1) return (m_step == 16'd0) ? "R9" : "R4";
    return "R3";
  endfunction

  initial begin
    logic [15:0] steps [12];
    logic [31:0] bases [2];
    steps = '{16'h0000, 16'h0001, 16'h0002, 16'h0FFF, 16'hF000, 16'hFFFF,
              16'h1000, 16'hEFFF, 16'h8000, 16'h7FFF, 16'h0800, 16'hFF00};
    bases = '{32'h0000_0000, 32'hFFFF_F800};
    do_reset();
    for (int s = 0; s < 12; s++) begin
      do_reset();
      cyc("R6", 1, 2'd2, 32'h0000_0005, 0, 0);
      cyc("R6", 1, 2'd2, {16'hABCD, steps[s]}, 0, 0);
      for (int b = 0; b < 2; b++) begin
        for (int z = 0; z < 4; z++) begin
          cyc("R2", 1, 2'd0, bases[b], 0, 0);
          cyc("R2", 1, 2'd1, {16'h0000, 16'(z)}, 0, 0);
          for (int k = 0; k < 9; k++) begin
            if (k == 4) cyc("R7", 1, 2'd0, 32'h1234_5678, 1, 1);
            cyc(burst_tag(), 0, 2'd0, '0, 1, 0);
          end
          cyc("R7", 1, 2'd2, 32'h0000_9000, 0, 1);
          cyc("R2", 1, 2'd3, 32'hDEAD_BEEF, 0, 0);
        end
      end
    end
    // same-cycle write and burst
    do_reset();
    cyc("R6", 1, 2'd2, 32'h0000_0010, 0, 0);
    cyc("R2", 1, 2'd0, 32'h0000_1000, 0, 0);
    cyc("R2", 1, 2'd1, 32'h0000_0001, 0, 0);
    cyc("R8", 1, 2'd2, 32'h0000_0100, 1, 0);   // expiry uses old step 0x10
    cyc("R8", 1, 2'd0, 32'h0000_2000, 1, 0);   // begin write beats the wrap
    cyc("R8", 1, 2'd1, 32'h0000_0003, 1, 0);   // size write beats the reload
    cyc("R8", 1, 2'd0, 32'h0000_3000, 1, 0);   // count drops, pointer written
    cyc("R3", 0, 2'd0, '0, 1, 0);
    cyc("R4", 0, 2'd0, '0, 1, 0);
    cyc("R6", 1, 2'd2, 32'h0000_1000, 0, 0);
    cyc("R6", 1, 2'd2, 32'h0000_0001, 0, 0);
    do_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule